// File: doc/BRIEF.md
# Floating-Point Data-Set Accumulator with Range Flags

The block sums a stream of single-precision floating-point samples. Each sample is aligned into a wide two's-complement fixed-point accumulator. The weights of the accumulator's lowest and highest bits are fixed by parameters, so the running total is kept exactly inside that window. Every cycle the total is converted back to single precision and driven out. A one-cycle start strobe arrives with the first sample of a data set. It makes the accumulator load that sample instead of adding it, so sets of any length can follow one another with no idle cycles between them.

Three flags travel down the pipeline with the sum. One flags a sample too large for the window, or a sample that is infinity or NaN. One flags a sample too small to reach the lowest accumulator bit. One flags a running total that has left the accumulator range. Each flag stays raised until the next start strobe. A clock enable freezes the whole pipeline.

Top module: `fp_set_accum`

## Requirements
- R1: When `setStart` is high with a sample, the sum reported for that sample equals that sample alone, whatever the previous total was.
- R2: When `setStart` is low, the reported sum is the previous total plus the sample. A new set may start on the cycle directly after the last sample of the previous set.
- R3: A sample is flagged on `inOverflow` when its exponent field is 0xFF (infinity or NaN), or when its unbiased exponent is greater than `IN_MAX_EXP` (default 30). An unbiased exponent of exactly `IN_MAX_EXP` is accepted with no flag.
- R4: A sample with a nonzero, non-0xFF exponent field whose unbiased exponent is below `ACC_LSB` (default -20) raises `inUnderflow` and adds nothing. The sum stays valid.
- R5: `accOverflow` is raised when the true running total leaves the range [-2^(ACC_MSB+1), 2^(ACC_MSB+1)) (default ACC_MSB = 30). A total of exactly -2^(ACC_MSB+1) is in range.
- R6: Each flag, once raised, stays high for the rest of the data set. The next start strobe clears it, and the new set then shows only the flags caused by its own samples.
- R7: The sum and flags for a sample appear after 3 rising clock edges with `clkEn` high. While `clkEn` is low, no state changes and inputs are ignored.
- R8: Output conversion truncates toward zero. Sample bits below weight 2^ACC_LSB are dropped. A zero total is output as +0 (0x00000000). Samples with a zero exponent field (zero and subnormals) add nothing and raise no flag.
- R9: While `rst` (active high, asynchronous) is asserted, `sumOut` is 0 and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high asynchronous reset |
| clkEn | input | 1 | Pipeline enable; low stalls every stage |
| dataIn | input | 32 | Single-precision sample |
| setStart | input | 1 | High with the first sample of a new data set |
| sumOut | output | 32 | Running total in single precision |
| inOverflow | output | 1 | Sticky: a sample in this set was too large, infinite or NaN |
| inUnderflow | output | 1 | Sticky: a sample in this set was below the accumulator's lowest bit |
| accOverflow | output | 1 | Sticky: the running total left the accumulator range |

## Verification
The main function is driven with back-to-back sets of small positive values, then mixed-sign values that cancel to zero. Together these separate load from add and show the +0 encoding.

Further directed sets check the range edges:
- an exponent one below the lowest accumulator bit, against one that just reaches it with extra mantissa bits to drop;
- an exponent at `IN_MAX_EXP`, against one just above it, and infinity;
- two totals that reach +2^31 and -2^31, which separate a true overflow from the exactly representable most negative value.

Long-mantissa totals such as 1 - 2^30 show truncation rather than rounding. A stall with a changing start strobe on the input shows that a disabled cycle is ignored.

// File: rtl/fpacc_pkg.sv
package fpacc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic adv;      // pipeline advances this cycle
    logic restart;  // stage-1 sample opens a new set
  } accCtrlT;

  // Range class of the incoming sample
  typedef struct packed {
    logic tooBig;
    logic tooSmall;
  } inClassT;
endpackage

// File: rtl/fpacc_datapath.sv
module fpacc_datapath
  import fpacc_pkg::*;
#(
  parameter int ACC_LSB    = -20,
  parameter int ACC_MSB    = 30,
  parameter int IN_MAX_EXP = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  accCtrlT     ctrl,
  input  logic [31:0] dataIn,
  output inClassT     inClass,
  output logic        sumOvf,
  output logic [31:0] sumOut
);
  localparam int W = ACC_MSB - ACC_LSB + 2;
  localparam int MANT_W = 24;

  logic [7:0]        expField;
  int                unbExp;
  int                sh;
  logic [MANT_W-1:0] mant;
  logic [W-1:0]      mag;
  logic [W-1:0]      addendD;
  logic [W-1:0]      addendQ;
  logic [W-1:0]      accQ;
  logic [W:0]        wideSum;

  // Sample decode and alignment onto the accumulator grid
  always_comb begin
    expField = dataIn[30:23];
    unbExp   = int'(expField) - 127;
    mant     = {1'b1, dataIn[22:0]};
    inClass.tooBig   = (expField == 8'hFF) || (expField != 8'h00 && unbExp > IN_MAX_EXP);
    inClass.tooSmall = (expField != 8'h00) && (expField != 8'hFF) && (unbExp < ACC_LSB);
    sh  = unbExp - (MANT_W - 1) - ACC_LSB;
    mag = '0;
    if (expField != 8'h00 && !inClass.tooBig && !inClass.tooSmall) begin
      if (sh >= 0) mag = W'(mant) << sh;
      else         mag = W'(mant) >> (-sh);
    end
    addendD = dataIn[31] ? -mag : mag;
  end

  // One extra bit catches a sum leaving the two's-complement range
  assign wideSum = {accQ[W-1], accQ} + {addendQ[W-1], addendQ};
  assign sumOvf  = wideSum[W] ^ wideSum[W-1];

  function automatic logic [31:0] toFloat(input logic [W-1:0] v);
    logic         neg;
    logic [W-1:0] mg;
    logic [W-1:0] nrm;
    int           lead;
    logic [7:0]   bexp;
    neg  = v[W-1];
    mg   = neg ? -v : v;
    lead = 0;
    for (int i = 0; i < W; i++) if (mg[i]) lead = i;
    nrm  = mg << (W - 1 - lead);
    bexp = 8'(lead + ACC_LSB + 127);
    if (mg == '0) return 32'h0;
    return {neg, bexp, nrm[W-2 -: 23]};
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addendQ <= '0;
      accQ    <= '0;
      sumOut  <= '0;
    end else if (ctrl.adv) begin
      addendQ <= addendD;
      accQ    <= ctrl.restart ? addendQ : wideSum[W-1:0];
      sumOut  <= toFloat(accQ);
    end
  end

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl.adv && ctrl.restart |=> accQ == $past(addendQ));
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.adv |=> $stable(accQ) && $stable(sumOut));
  p_pos_zero_r8: assert property (@(posedge clk) disable iff (rst)
    sumOut[30:0] == 31'h0 |-> !sumOut[31]);
endmodule

// File: rtl/fpacc_ctrl.sv
module fpacc_ctrl
  import fpacc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clkEn,
  input  logic    setStart,
  input  inClassT inClass,
  input  logic    sumOvf,
  output accCtrlT ctrl,
  output logic    inOverflow,
  output logic    inUnderflow,
  output logic    accOverflow
);
  logic startQ, s1Ovf, s1Unf;
  logic stOvf, stUnf, stAcc;

  assign ctrl.adv     = clkEn;
  assign ctrl.restart = startQ;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      startQ <= 1'b0; s1Ovf <= 1'b0; s1Unf <= 1'b0;
      stOvf  <= 1'b0; stUnf <= 1'b0; stAcc <= 1'b0;
      inOverflow <= 1'b0; inUnderflow <= 1'b0; accOverflow <= 1'b0;
    end else if (clkEn) begin
      startQ <= setStart;
      s1Ovf  <= inClass.tooBig;
      s1Unf  <= inClass.tooSmall;
      if (startQ) begin
        stOvf <= s1Ovf;
        stUnf <= s1Unf;
        stAcc <= 1'b0;
      end else begin
        stOvf <= stOvf | s1Ovf;
        stUnf <= stUnf | s1Unf;
        stAcc <= stAcc | sumOvf;
      end
      inOverflow  <= stOvf;
      inUnderflow <= stUnf;
      accOverflow <= stAcc;
    end
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    clkEn && !startQ && stUnf |=> stUnf);
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clkEn && startQ |=> !stAcc);
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> $stable(inOverflow) && $stable(inUnderflow) && $stable(accOverflow));
endmodule

// File: rtl/fp_set_accum.sv
module fp_set_accum
  import fpacc_pkg::*;
#(
  parameter int ACC_LSB    = -20,
  parameter int ACC_MSB    = 30,
  parameter int IN_MAX_EXP = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clkEn,
  input  logic [31:0] dataIn,
  input  logic        setStart,
  output logic [31:0] sumOut,
  output logic        inOverflow,
  output logic        inUnderflow,
  output logic        accOverflow
);
  accCtrlT ctrl;
  inClassT inClass;
  logic    sumOvf;

  fpacc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clkEn(clkEn), .setStart(setStart),
    .inClass(inClass), .sumOvf(sumOvf), .ctrl(ctrl),
    .inOverflow(inOverflow), .inUnderflow(inUnderflow), .accOverflow(accOverflow)
  );

  fpacc_datapath #(.ACC_LSB(ACC_LSB), .ACC_MSB(ACC_MSB), .IN_MAX_EXP(IN_MAX_EXP)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dataIn(dataIn),
    .inClass(inClass), .sumOvf(sumOvf), .sumOut(sumOut)
  );
endmodule

// File: tb/test_fp_set_accum.sv
module test_fp_set_accum;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, clkEn, setStart;
  logic [31:0] dataIn;
  logic [31:0] sumOut;
  logic        inOverflow, inUnderflow, accOverflow;

  int cmpCnt = 0;
  int misCnt = 0;

  // Stream tables: sample, start, expected sum, expected {checkSum, ovf, unf, acc}
  logic [31:0] sx [8];
  logic        ss [8];
  logic [31:0] er [8];
  logic [3:0]  ef [8];

  always #(PERIOD/2) clk = ~clk;

  fp_set_accum i_fp_set_accum (
    .clk(clk), .rst(rst), .clkEn(clkEn), .dataIn(dataIn), .setStart(setStart),
    .sumOut(sumOut), .inOverflow(inOverflow), .inUnderflow(inUnderflow),
    .accOverflow(accOverflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    cmpCnt++;
    if (act !== exp) begin
      misCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setRow(input int i, input logic [31:0] x, input logic s,
                        input logic [31:0] r, input logic [3:0] f);
    sx[i] = x; ss[i] = s; er[i] = r; ef[i] = f;
  endtask

  // Output for sample k is checked at the falling edge after its 3rd rising edge
  task automatic runStream(input int n, input string req);
    for (int t = 0; t < n + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        if (ef[t-3][3]) check({req, " sum"}, sumOut, er[t-3]);
        check({req, " ovf"}, {31'h0, inOverflow},  {31'h0, ef[t-3][2]});
        check({req, " unf"}, {31'h0, inUnderflow}, {31'h0, ef[t-3][1]});
        check({req, " acc"}, {31'h0, accOverflow}, {31'h0, ef[t-3][0]});
      end
      if (t < n) begin dataIn = sx[t]; setStart = ss[t]; end
      else       begin dataIn = 32'h0; setStart = 1'b0; end
    end
  endtask

  task automatic testReset();
    rst = 1'b1; clkEn = 1'b1; dataIn = 32'h3F800000; setStart = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 sum", sumOut, 32'h0);
    check("R9 flags", {29'h0, inOverflow, inUnderflow, accOverflow}, 32'h0);
    dataIn = 32'h0; setStart = 1'b0;
    rst = 1'b0;
  endtask

  task automatic testLoadAdd();  // R1, R2: back-to-back sets
    setRow(0, 32'h3F800000, 1, 32'h3F800000, 4'b1000);
    setRow(1, 32'h40000000, 0, 32'h40400000, 4'b1000);
    setRow(2, 32'h3F000000, 0, 32'h40600000, 4'b1000);
    setRow(3, 32'h41200000, 1, 32'h41200000, 4'b1000);
    setRow(4, 32'hC0200000, 0, 32'h40F00000, 4'b1000);
    runStream(5, "R1/R2");
  endtask

  task automatic testSignZero();  // R8: cancel to +0, subnormal adds nothing
    setRow(0, 32'hBF800000, 1, 32'hBF800000, 4'b1000);
    setRow(1, 32'h3F800000, 0, 32'h00000000, 4'b1000);
    setRow(2, 32'hC0200000, 0, 32'hC0200000, 4'b1000);
    setRow(3, 32'h3F800000, 1, 32'h3F800000, 4'b1000);
    setRow(4, 32'h00400000, 0, 32'h3F800000, 4'b1000);
    runStream(5, "R8");
  endtask

  task automatic testUnderflow();  // R4, R6, R8 truncation of low bits
    setRow(0, 32'h3F800000, 1, 32'h3F800000, 4'b1000);
    setRow(1, 32'h35000000, 0, 32'h3F800000, 4'b1010);
    setRow(2, 32'h3F800000, 0, 32'h40000000, 4'b1010);
    setRow(3, 32'h40800000, 1, 32'h40800000, 4'b1000);
    setRow(4, 32'h35C00000, 1, 32'h35800000, 4'b1000);
    runStream(5, "R4/R6");
  endtask

  task automatic testInOverflow();  // R3, R6
    setRow(0, 32'h4F000000, 1, 32'h0, 4'b0100);
    setRow(1, 32'h3F800000, 0, 32'h0, 4'b0100);
    setRow(2, 32'h7F800000, 1, 32'h0, 4'b0100);
    setRow(3, 32'h3F800000, 1, 32'h3F800000, 4'b1000);
    setRow(4, 32'h4E800000, 0, 32'h4E800000, 4'b1000);
    runStream(5, "R3");
  endtask

  task automatic testAccOverflow();  // R5, R6
    setRow(0, 32'h4E800000, 1, 32'h4E800000, 4'b1000);
    setRow(1, 32'h4E800000, 0, 32'h0, 4'b0001);
    setRow(2, 32'hCE800000, 0, 32'h0, 4'b0001);
    setRow(3, 32'h3F800000, 1, 32'h3F800000, 4'b1000);
    setRow(4, 32'hCE800000, 0, 32'hCE7FFFFF, 4'b1000);
    setRow(5, 32'hCE800000, 0, 32'hCEFFFFFF, 4'b1000);
    setRow(6, 32'hCE800000, 1, 32'hCE800000, 4'b1000);
    setRow(7, 32'hCE800000, 0, 32'hCF000000, 4'b1000);
    runStream(8, "R5");
  endtask

  task automatic testStall();  // R7
    logic [31:0] held;
    @(negedge clk);
    dataIn = 32'h3F800000; setStart = 1'b1;
    @(negedge clk);
    held = sumOut;
    clkEn = 1'b0; dataIn = 32'h40400000; setStart = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 stall sum", sumOut, held);
    clkEn = 1'b1; dataIn = 32'h40000000; setStart = 1'b0;
    @(negedge clk);
    dataIn = 32'h0;
    repeat (4) @(negedge clk);
    check("R7 resume sum", sumOut, 32'h40400000);
    check("R7 resume flags", {29'h0, inOverflow, inUnderflow, accOverflow}, 32'h0);
  endtask

  initial begin
    #(PERIOD * 150000);
    misCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, misCnt);
    $finish;
  end

  initial begin
    testReset();
    testLoadAdd();
    testSignZero();
    testUnderflow();
    testInOverflow();
    testAccOverflow();
    testStall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, misCnt);
    $finish;
  end
endmodule